// File: doc/BRIEF.md
# Two-wire synchronous programming link transceiver

This block is the master end of the physical layer of a two-wire synchronous programming link. One wire is a clock that the master generates. The other is a single data wire that carries traffic in both directions. The link clock comes from the system clock through a programmable half-period divider. Outgoing bytes are wrapped in 12-bit frames and shifted out. Response frames are shifted in on the same wire, and the block switches the direction of the data wire cleanly between the two.

The user side has four parts. A byte-in valid/ready pair accepts bytes to send. A one-cycle byte-out strobe delivers received bytes, together with a parity-error flag. An `rx_arm` strobe asks for one response frame. Separate strobes start the link, stop the link and request a BREAK. Starting the link holds data high before any clock edge, which keeps the target out of reset, and then sends two BREAK frames automatically. Command decoding and memory programming are handled by logic above this block.

Top module: `prog_link_phy`

## Requirements
- R1: A transmitted frame has 12 bit times. It holds a low start bit, then the 8 data bits least significant first, then an even-parity bit (XOR of the 8 data bits), then two high stop bits.
- R2: While the master drives the data wire, `dat_o` changes only in the cycle in which `link_clk` falls.
- R3: In receive, `dat_i` is sampled on rising edges of `link_clk`. The frame does not start while the line reads high; it starts at the first low start bit.
- R4: A received frame yields a one-cycle `rx_valid` with the 8 data bits on `rx_data`. `rx_perr` is high in that same cycle only when the received parity bit differs from the XOR of the data bits.
- R5: When the master takes the data wire back from receive, `dat_o` is already high in the cycle `dat_oe` rises.
- R6: An `rx_arm` strobe given during a transmit frame is held until that frame completes, including both stop bits. Only then is `dat_oe` dropped to release the wire.
- R7: On `en_req`, `clk_oe` and `dat_oe` go high with `dat_o` high. `link_clk` then stays low for at least `SETUP_CYC` system cycles (10 cycles = 100 ns at 100 MHz, above the 90 ns minimum).
- R8: After enable, two BREAK frames are sent before any user byte, and `tx_ready` stays low until both are done.
- R9: A `brk_req` strobe sends one BREAK: 12 consecutive bit times with the data line low.
- R10: On `dis_req`, `clk_oe` and `dat_oe` drop in the next cycle and `link_clk` stays low.
- R11: Each half period of `link_clk` lasts `DIV` system cycles, so a full link clock period is `2*DIV` cycles.
- R12: After reset both wires are released, `link_clk` is low, `tx_ready` is low and no byte is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Strobe: start the link (setup hold, then two BREAKs) |
| dis_req | input | 1 | Strobe: stop the clock and release both wires |
| brk_req | input | 1 | Strobe: queue one BREAK frame |
| rx_arm | input | 1 | Strobe: receive one frame after any current transmit |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block will take `tx_data` at this edge |
| rx_data | output | 8 | Received data byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_data` valid |
| rx_perr | output | 1 | Parity mismatch on the byte strobed by `rx_valid` |
| link_clk | output | 1 | Link clock level |
| clk_oe | output | 1 | Drive enable for the link clock wire |
| dat_o | output | 1 | Data wire output level |
| dat_oe | output | 1 | Drive enable for the data wire |
| dat_i | input | 1 | Data wire level as read back |

## Verification
The embedded properties check these rules on every cycle: data edges line up with falling link clock edges, the data wire is high before the master takes it back, the wire is released whenever a received byte is reported, the error flag appears only with a valid strobe, and both wires are released after a stop. Some behaviour can only be shown by the bench scenarios. These are the bit-exact frame layout and parity, the wait for a start bit, the setup hold and the two BREAKs after enable, the deferral of a receive request until a transmit frame ends, and the link clock period.

// File: rtl/prog_link_phy.sv
module prog_link_phy #(
  parameter int DIV       = 8,
  parameter int SETUP_CYC = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic       dis_req,
  input  logic       brk_req,
  input  logic       rx_arm,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_perr,
  output logic       link_clk,
  output logic       clk_oe,
  output logic       dat_o,
  output logic       dat_oe,
  input  logic       dat_i
);
  localparam int CMAX = (DIV > SETUP_CYC) ? DIV : SETUP_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int FLEN = 12;

  typedef enum logic [2:0] {S_OFF, S_SETUP, S_IDLE, S_TX, S_RX} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [FLEN-1:0] sh;
  logic [3:0]     bcnt;
  logic [1:0]     brk_cnt;
  logic           rx_pend;

  wire running = (st == S_IDLE) || (st == S_TX) || (st == S_RX);
  wire tick    = running && (cnt == CW'(DIV - 1));
  wire fall    = tick && link_clk;
  wire rise    = tick && !link_clk;
  wire [FLEN-1:0] nsh = {dat_i, sh[FLEN-1:1]};
  wire wait_start = (bcnt == 4'(FLEN)) && dat_i;

  assign tx_ready = (st == S_IDLE) && (brk_cnt == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_OFF;
      cnt      <= '0;
      link_clk <= 1'b0;
      clk_oe   <= 1'b0;
      dat_oe   <= 1'b0;
      dat_o    <= 1'b1;
      sh       <= '0;
      bcnt     <= '0;
      brk_cnt  <= '0;
      rx_pend  <= 1'b0;
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      rx_perr  <= 1'b0;
      if (rx_arm && st != S_OFF) rx_pend <= 1'b1;
      if (brk_req && st != S_OFF && brk_cnt == 2'd0) brk_cnt <= 2'd1;
      if (tick) cnt <= '0;
      else if (st != S_OFF) cnt <= cnt + 1'b1;
      if (tick) link_clk <= ~link_clk;

      if (dis_req && st != S_OFF) begin
        st       <= S_OFF;
        clk_oe   <= 1'b0;
        dat_oe   <= 1'b0;
        dat_o    <= 1'b1;
        link_clk <= 1'b0;
        cnt      <= '0;
        brk_cnt  <= '0;
        rx_pend  <= 1'b0;
      end else begin
        case (st)
          S_OFF: if (en_req) begin
            st      <= S_SETUP;
            clk_oe  <= 1'b1;
            dat_oe  <= 1'b1;
            dat_o   <= 1'b1;
            cnt     <= '0;
            brk_cnt <= 2'd2;
          end
          S_SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin
            st  <= S_IDLE;
            cnt <= '0;
          end
          S_IDLE: begin
            if (brk_cnt != 2'd0) begin
              sh      <= '0;
              bcnt    <= 4'(FLEN);
              st      <= S_TX;
              dat_oe  <= 1'b1;
              brk_cnt <= brk_cnt - 2'd1;
            end else if (tx_valid) begin
              sh     <= {2'b11, ^tx_data, tx_data, 1'b0};
              bcnt   <= 4'(FLEN);
              st     <= S_TX;
              dat_oe <= 1'b1;
            end else if (rx_pend) begin
              st      <= S_RX;
              dat_oe  <= 1'b0;
              dat_o   <= 1'b1;
              bcnt    <= 4'(FLEN);
              rx_pend <= 1'b0;
            end
          end
          S_TX: if (fall) begin
            if (bcnt == 4'd0) begin
              st    <= S_IDLE;
              dat_o <= 1'b1;
            end else begin
              dat_o <= sh[0];
              sh    <= sh >> 1;
              bcnt  <= bcnt - 4'd1;
            end
          end
          S_RX: if (rise && !wait_start) begin
            sh   <= nsh;
            bcnt <= bcnt - 4'd1;
            if (bcnt == 4'd1) begin
              st       <= S_IDLE;
              rx_valid <= 1'b1;
              rx_data  <= nsh[8:1];
              rx_perr  <= ^nsh[9:1];
            end
          end
          default: st <= S_OFF;
        endcase
      end
    end
  end

  p_high_before_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> dat_o);

  p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe && $past(dat_oe) && (dat_o != $past(dat_o))) |-> (!link_clk && $past(link_clk)));

  p_perr_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_perr |-> rx_valid);

  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_released_on_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !dat_oe);

  p_release_on_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_req) |-> (!clk_oe && !dat_oe));

  p_clk_low_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe |-> !link_clk);
endmodule

// File: tb/prog_link_phy_bench.sv
module prog_link_phy_bench;
  localparam int DIV = 4;
  localparam int SETUP_CYC = 10;
  localparam bit [8:0] VEC [0:5] = '{9'h0A5, 9'h000, 9'h1FF, 9'h03C, 9'h180, 9'h101};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_req = 0, dis_req = 0, brk_req = 0, rx_arm = 0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 0;
  logic tx_ready;
  logic [7:0] rx_data;
  logic rx_valid, rx_perr, link_clk, clk_oe, dat_o, dat_oe;
  logic dat_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  prog_link_phy #(.DIV(DIV), .SETUP_CYC(SETUP_CYC)) u_prog_link_phy (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req), .brk_req(brk_req),
    .rx_arm(rx_arm), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr), .link_clk(link_clk),
    .clk_oe(clk_oe), .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  logic oe_q = 1'b0;
  always @(negedge clk) begin
    if (rst_n && dat_oe && !oe_q) chk(dat_o === 1'b1, "R5", dat_o, 1);
    oe_q <= dat_oe;
  end

  task automatic next_rise();
    logic p;
    p = link_clk;
    forever begin
      @(negedge clk);
      if (link_clk && !p) break;
      p = link_clk;
    end
  endtask

  task automatic next_fall();
    logic p;
    p = link_clk;
    forever begin
      @(negedge clk);
      if (!link_clk && p) break;
      p = link_clk;
    end
  endtask

  task automatic get_frame(output logic [11:0] f, output bit oe_held);
    oe_held = 1;
    do next_rise(); while (!(dat_oe && dat_o == 1'b0));
    f[0] = dat_o;
    for (int i = 1; i < 12; i++) begin
      next_rise();
      f[i] = dat_o;
      if (!dat_oe) oe_held = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    tx_data = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  task automatic drive_frame(input logic [7:0] b, input bit bad);
    logic [11:0] bits;
    bits = {2'b11, (^b) ^ bad, b, 1'b0};
    repeat (2) next_fall();
    for (int i = 0; i < 12; i++) begin
      next_fall();
      dat_i = bits[i];
    end
    next_fall();
    dat_i = 1'b1;
  endtask

  task automatic wait_rx(output logic [7:0] d, output logic pe, output bit single);
    forever begin
      @(negedge clk);
      if (rx_valid) break;
    end
    d = rx_data;
    pe = rx_perr;
    @(negedge clk);
    single = !rx_valid;
  endtask

  task automatic wait_idle();
    while (!tx_ready) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [11:0] f;
    bit held, single;
    logic [7:0] d;
    logic pe;
    int n;

    repeat (3) @(negedge clk);
    chk(!clk_oe && !dat_oe && !link_clk && !tx_ready && !rx_valid, "R12",
        {clk_oe, dat_oe, link_clk, tx_ready, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!clk_oe && !dat_oe && !tx_ready, "R12", {clk_oe, dat_oe, tx_ready}, 0);

    pulse(en_req);
    chk(clk_oe && dat_oe && dat_o, "R7", {clk_oe, dat_oe, dat_o}, 3'b111);
    n = 1;
    while (!link_clk) begin
      @(negedge clk);
      n++;
    end
    chk(n >= SETUP_CYC, "R7", n, SETUP_CYC);

    get_frame(f, held);
    chk(f == 12'h000, "R8", f, 12'h000);
    chk(!tx_ready, "R8", tx_ready, 0);
    get_frame(f, held);
    chk(f == 12'h000, "R8", f, 12'h000);

    next_rise();
    n = 0;
    begin
      logic p;
      p = link_clk;
      forever begin
        @(negedge clk);
        n++;
        if (link_clk && !p) break;
        p = link_clk;
      end
    end
    chk(n == 2 * DIV, "R11", n, 2 * DIV);
    wait_idle();

    for (int i = 0; i < 6; i++) begin
      logic [7:0] b;
      bit bad;
      b = VEC[i][7:0];
      bad = VEC[i][8];
      fork
        send_byte(b);
        get_frame(f, held);
      join
      chk(f == {2'b11, ^b, b, 1'b0}, "R1", f, {2'b11, ^b, b, 1'b0});
      wait_idle();
      pulse(rx_arm);
      while (dat_oe) @(negedge clk);
      fork
        drive_frame(b, bad);
        wait_rx(d, pe, single);
      join
      chk(d == b, "R3 R4 data", d, b);
      chk(pe == bad, "R4 parity flag", pe, bad);
      chk(single, "R4 strobe width", single, 1);
    end

    wait_idle();
    fork
      send_byte(8'h6E);
      begin
        repeat (3) @(negedge clk);
        rx_arm = 1'b1;
        @(negedge clk);
        rx_arm = 1'b0;
      end
      get_frame(f, held);
    join
    chk(f == {2'b11, ^8'h6E, 8'h6E, 1'b0}, "R6 frame", f, {2'b11, ^8'h6E, 8'h6E, 1'b0});
    chk(held && dat_oe, "R6 hold", {held, dat_oe}, 2'b11);
    n = 0;
    while (dat_oe && n < 4 * DIV) begin
      @(negedge clk);
      n++;
    end
    chk(!dat_oe, "R6 release", dat_oe, 0);
    fork
      drive_frame(8'h81, 1'b0);
      wait_rx(d, pe, single);
    join
    chk(d == 8'h81 && !pe, "R6 rx", {pe, d}, 9'h081);

    wait_idle();
    fork
      pulse(brk_req);
      get_frame(f, held);
    join
    chk(f == 12'h000 && held, "R9", f, 12'h000);

    wait_idle();
    pulse(dis_req);
    chk(!clk_oe && !dat_oe && !link_clk && !tx_ready, "R10",
        {clk_oe, dat_oe, link_clk, tx_ready}, 0);
    n = 0;
    repeat (40) begin
      @(negedge clk);
      if (link_clk || clk_oe || dat_oe) n++;
    end
    chk(n == 0, "R10 quiet", n, 0);

    finish_run();
  end
endmodule